// File: doc/BRIEF.md
# Dual Data Pointer Register Unit

This unit sits beside an 8051-class core and holds two 16-bit data pointers together with a small auxiliary control register. One bit of that control register picks which pointer is active. The active pointer drives the 16-bit address that the core uses for external data moves, indexed code fetches and indirect jumps. The core reaches the pointer bytes and the control register through ordinary special-function-register (SFR) reads and writes. It also issues two pointer commands: increment by one, and load a 16-bit immediate.

The control register also holds a general-purpose flag and a boot-enable flag. Bit 2 of the register is hard-wired to zero. Because of that bit, software can add one to the register value and write the result back, and this flips the pointer selection without carrying into the flag at bit 3. The boot-enable flag is captured while reset is held. It is set if a nonzero boot status byte is present, or if the strobe, latch and access pins are in the boot-request state. Software can overwrite it later.

Top module: `dptr_pair_unit`

## Requirements
- R1: Bit 0 of the control register at SFR address A2H selects pointer 0 when 0 and pointer 1 when 1. `addr_out` always shows the selected pointer. A pointer that is not selected keeps its value.
- R2: An SFR write to 82H replaces the low byte of the selected pointer, and a write to 83H replaces its high byte. Reads of 82H and 83H return the bytes of the selected pointer only.
- R3: Command code 1 (increment) adds 1 to the selected pointer in one clock. The low-byte carry reaches the high byte in that same clock, and FFFFH wraps to 0000H.
- R4: Command code 2 (load) writes `ptr_imm` into the selected pointer only. Codes 0 and 3 do nothing.
- R5: Reading the control register returns bit 0 = select, bit 3 = user flag, bit 5 = boot enable, and 0 in bits 1, 2, 4, 6 and 7. Writes to those zero bits have no effect.
- R6: Reading the control register, adding 1 and writing the result back toggles the select bit and leaves the user flag unchanged.
- R7: After reset both pointers are 0000H and the select bit and the user flag are 0.
- R8: While `rst_n` is low, boot enable takes the value (`boot_status` != 0) OR (`psen_n` low AND `ale_pin` high AND `ea_high` high). It holds that value after reset is released until software writes bit 5 of the control register.
- R9: When an SFR byte write and a pointer command arrive in the same cycle, the command decides the new pointer value.
- R10: Register reads are combinational and show the values held before the coming clock edge. Any SFR address other than 82H, 83H and A2H reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_addr | input | 8 | SFR address from the core |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data for the addressed register |
| ptr_cmd | input | 2 | Pointer command: 0 none, 1 increment, 2 load, 3 none |
| ptr_imm | input | 16 | Immediate value for the load command |
| addr_out | output | 16 | Selected pointer, used as the external-data / code-index address |
| boot_status | input | 8 | Boot status byte, looked at during reset |
| psen_n | input | 1 | Sampled program-strobe pin, active low |
| ale_pin | input | 1 | Sampled address-latch pin level |
| ea_high | input | 1 | External-access pin is above the input-high threshold |
| boot_en | output | 1 | Boot-enable flag |

## Verification
The bench builds the unit with its default parameters: 16-bit pointers, 8-bit SFR bytes and the standard SFR addresses 82H, 83H and A2H. With these values the full-width wrap from FFFFH can be reached in one load and one increment. The low-to-high carry from 00FFH is reachable in the same way. Resets with different pin patterns cover each term of the boot-enable expression. A read-add-write sequence on the control register exercises the hard-wired zero bit, with the user flag set.

// File: rtl/dptr_pkg.sv
// Shared types for the dual data pointer unit.
// Assumes a two-bit command field driven by the core's decode logic.
package dptr_pkg;

    typedef enum logic [1:0] {
        PCMD_NOP  = 2'd0,
        PCMD_INC  = 2'd1,
        PCMD_LOAD = 2'd2,
        PCMD_RSVD = 2'd3
    } ptr_cmd_e;

    localparam int NUM_PTR = 2;

endpackage

// File: rtl/dptr_bank.sv
// Storage for the two data pointers.
// Only the pointer chosen by sel is touched. A command (increment or load)
// takes priority over an SFR byte write to the same pointer.
// Assumes PTR_W equals two SFR bytes.
module dptr_bank #(
    parameter int PTR_W  = 16,
    parameter int DATA_W = 8
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 sel,
    input  logic                                 wr_lo,
    input  logic                                 wr_hi,
    input  logic [DATA_W-1:0]                    wdata,
    input  logic                                 do_inc,
    input  logic                                 do_load,
    input  logic [PTR_W-1:0]                     imm,
    output logic [dptr_pkg::NUM_PTR-1:0][PTR_W-1:0] ptr_q
);
    localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

    for (genvar i = 0; i < dptr_pkg::NUM_PTR; i++) begin : g_ptr
        logic hit;
        assign hit = (sel == 1'(i));

        // Update one pointer: command first, then byte writes.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ptr_q[i] <= '0;
            end else if (hit) begin
                if (do_inc) begin
                    ptr_q[i] <= ptr_q[i] + ONE;
                end else if (do_load) begin
                    ptr_q[i] <= imm;
                end else if (wr_lo) begin
                    ptr_q[i][DATA_W-1:0] <= wdata;
                end else if (wr_hi) begin
                    ptr_q[i][PTR_W-1:DATA_W] <= wdata;
                end
            end
        end
    end
endmodule

// File: rtl/dptr_auxreg.sv
// Auxiliary control register: pointer select, user flag, boot enable.
// Unimplemented bits read 0 and ignore writes. Boot enable is reloaded from
// the pin and status conditions on every clock while reset is held.
module dptr_auxreg #(
    parameter int DATA_W   = 8,
    parameter int SEL_BIT  = 0,
    parameter int FLAG_BIT = 3,
    parameter int BOOT_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] boot_status,
    input  logic              psen_n,
    input  logic              ale_pin,
    input  logic              ea_high,
    output logic              sel,
    output logic              boot_en,
    output logic [DATA_W-1:0] rd_val
);
    logic flag;
    logic boot_req;

    // Boot request seen at the pins or in the status byte.
    assign boot_req = (boot_status != '0) | (~psen_n & ale_pin & ea_high);

    // Select bit and user flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel  <= 1'b0;
            flag <= 1'b0;
        end else if (wr) begin
            sel  <= wdata[SEL_BIT];
            flag <= wdata[FLAG_BIT];
        end
    end

    // Boot-enable flag: follows the request during reset, writable after.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            boot_en <= boot_req;
        end else if (wr) begin
            boot_en <= wdata[BOOT_BIT];
        end
    end

    // Assemble the read value with every other bit at zero.
    always_comb begin
        rd_val           = '0;
        rd_val[SEL_BIT]  = sel;
        rd_val[FLAG_BIT] = flag;
        rd_val[BOOT_BIT] = boot_en;
    end
endmodule

// File: rtl/dptr_sfr_mux.sv
// SFR read multiplexer. Purely combinational, so a read shows the values
// held before the next clock edge. Unmapped addresses return zero.
module dptr_sfr_mux #(
    parameter int               DATA_W  = 8,
    parameter int               ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] ADDR_LO  = 8'h82,
    parameter logic [ADDR_W-1:0] ADDR_HI  = 8'h83,
    parameter logic [ADDR_W-1:0] ADDR_AUX = 8'hA2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] lo_byte,
    input  logic [DATA_W-1:0] hi_byte,
    input  logic [DATA_W-1:0] aux_byte,
    output logic [DATA_W-1:0] rdata
);
    // Pick the addressed byte.
    always_comb begin
        if (addr == ADDR_LO) begin
            rdata = lo_byte;
        end else if (addr == ADDR_HI) begin
            rdata = hi_byte;
        end else if (addr == ADDR_AUX) begin
            rdata = aux_byte;
        end else begin
            rdata = '0;
        end
    end
endmodule

// File: rtl/dptr_pair_unit.sv
// Dual data pointer unit top level.
// Decodes SFR writes and pointer commands, keeps two pointers and the
// auxiliary register, and drives the selected pointer out as an address.
// Assumes one SFR access and at most one pointer command per cycle.
module dptr_pair_unit #(
    parameter int               PTR_W    = 16,
    parameter int               DATA_W   = 8,
    parameter int               ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] ADDR_LO  = 8'h82,
    parameter logic [ADDR_W-1:0] ADDR_HI  = 8'h83,
    parameter logic [ADDR_W-1:0] ADDR_AUX = 8'hA2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic              sfr_wr,
    input  logic [DATA_W-1:0] sfr_wdata,
    output logic [DATA_W-1:0] sfr_rdata,
    input  logic [1:0]        ptr_cmd,
    input  logic [PTR_W-1:0]  ptr_imm,
    output logic [PTR_W-1:0]  addr_out,
    input  logic [DATA_W-1:0] boot_status,
    input  logic              psen_n,
    input  logic              ale_pin,
    input  logic              ea_high,
    output logic              boot_en
);
    import dptr_pkg::*;

    ptr_cmd_e                    cmd;
    logic                        sel;
    logic                        wr_lo, wr_hi, wr_aux;
    logic [NUM_PTR-1:0][PTR_W-1:0] ptr_q;
    logic [DATA_W-1:0]           aux_val;

    // Decode the command and the write targets.
    assign cmd    = ptr_cmd_e'(ptr_cmd);
    assign wr_lo  = sfr_wr && (sfr_addr == ADDR_LO);
    assign wr_hi  = sfr_wr && (sfr_addr == ADDR_HI);
    assign wr_aux = sfr_wr && (sfr_addr == ADDR_AUX);

    dptr_bank #(
        .PTR_W  (PTR_W),
        .DATA_W (DATA_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wdata   (sfr_wdata),
        .do_inc  (cmd == PCMD_INC),
        .do_load (cmd == PCMD_LOAD),
        .imm     (ptr_imm),
        .ptr_q   (ptr_q)
    );

    dptr_auxreg #(
        .DATA_W (DATA_W)
    ) u_aux (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr          (wr_aux),
        .wdata       (sfr_wdata),
        .boot_status (boot_status),
        .psen_n      (psen_n),
        .ale_pin     (ale_pin),
        .ea_high     (ea_high),
        .sel         (sel),
        .boot_en     (boot_en),
        .rd_val      (aux_val)
    );

    // The selected pointer is the external address.
    assign addr_out = ptr_q[sel];

    dptr_sfr_mux #(
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W),
        .ADDR_LO  (ADDR_LO),
        .ADDR_HI  (ADDR_HI),
        .ADDR_AUX (ADDR_AUX)
    ) u_mux (
        .addr     (sfr_addr),
        .lo_byte  (addr_out[DATA_W-1:0]),
        .hi_byte  (addr_out[PTR_W-1:DATA_W]),
        .aux_byte (aux_val),
        .rdata    (sfr_rdata)
    );
endmodule

// File: rtl/dptr_pair_checker.sv
// Property checker for the dual data pointer unit, bound to the top.
// Looks only at the top-level ports.
module dptr_pair_checker #(
    parameter int               PTR_W    = 16,
    parameter int               DATA_W   = 8,
    parameter int               ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] ADDR_LO  = 8'h82,
    parameter logic [ADDR_W-1:0] ADDR_HI  = 8'h83,
    parameter logic [ADDR_W-1:0] ADDR_AUX = 8'hA2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] sfr_addr,
    input logic              sfr_wr,
    input logic [DATA_W-1:0] sfr_wdata,
    input logic [DATA_W-1:0] sfr_rdata,
    input logic [1:0]        ptr_cmd,
    input logic [PTR_W-1:0]  ptr_imm,
    input logic [PTR_W-1:0]  addr_out,
    input logic [DATA_W-1:0] boot_status,
    input logic              psen_n,
    input logic              ale_pin,
    input logic              ea_high,
    input logic              boot_en
);
    logic aux_w, lo_w;
    assign aux_w = sfr_wr && (sfr_addr == ADDR_AUX);
    assign lo_w  = sfr_wr && (sfr_addr == ADDR_LO);

    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_cmd == 2'd1 && !aux_w) |=> addr_out == $past(addr_out) + PTR_W'(1)); // R3

    AST_LOAD_IMM: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_cmd == 2'd2 && !aux_w) |=> addr_out == $past(ptr_imm)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_cmd[0] == ptr_cmd[1] && !sfr_wr) |=> $stable(addr_out)); // R1

    AST_AUX_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr == ADDR_AUX) |-> (sfr_rdata[7:6] == 2'b00 && sfr_rdata[4] == 1'b0
                                    && sfr_rdata[2:1] == 2'b00)); // R5

    AST_BOOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_w |=> $stable(boot_en)); // R8

    AST_CMD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_cmd == 2'd2 && lo_w) |=> addr_out == $past(ptr_imm)); // R9

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr != ADDR_LO && sfr_addr != ADDR_HI && sfr_addr != ADDR_AUX)
        |-> sfr_rdata == '0); // R10
endmodule

bind dptr_pair_unit dptr_pair_checker #(
    .PTR_W    (PTR_W),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .ADDR_LO  (ADDR_LO),
    .ADDR_HI  (ADDR_HI),
    .ADDR_AUX (ADDR_AUX)
) u_chk (.*);

// File: tb/dptr_pair_unit_bench.sv
// Directed bench for the dual data pointer unit: one task per scenario.
module dptr_pair_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  sfr_addr = 8'h00;
    logic        sfr_wr = 1'b0;
    logic [7:0]  sfr_wdata = 8'h00;
    logic [7:0]  sfr_rdata;
    logic [1:0]  ptr_cmd = 2'd0;
    logic [15:0] ptr_imm = 16'h0000;
    logic [15:0] addr_out;
    logic [7:0]  boot_status = 8'h00;
    logic        psen_n = 1'b1;
    logic        ale_pin = 1'b0;
    logic        ea_high = 1'b0;
    logic        boot_en;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [7:0] A_LO = 8'h82, A_HI = 8'h83, A_AUX = 8'hA2;

    always #2.5 clk = ~clk;

    dptr_pair_unit u_dptr_pair_unit (.*);

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        tick();
        sfr_wr = 1'b0;
    endtask

    task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
        sfr_addr = a;
        #0.5;
        d = sfr_rdata;
    endtask

    task automatic issue(input logic [1:0] c, input logic [15:0] v);
        ptr_cmd = c; ptr_imm = v;
        tick();
        ptr_cmd = 2'd0;
    endtask

    task automatic do_reset(input logic [7:0] st, input logic ps, input logic al, input logic ea);
        boot_status = st; psen_n = ps; ale_pin = al; ea_high = ea;
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        boot_status = 8'h00; psen_n = 1'b1; ale_pin = 1'b0; ea_high = 1'b0;
        tick();
    endtask

    // Reset state and boot capture (R7, R8).
    task automatic t_reset_boot();
        logic [7:0] d;
        do_reset(8'h00, 1'b1, 1'b0, 1'b0);
        check("R7 addr_out after reset", addr_out, 16'h0000);
        sfr_read(A_AUX, d);
        check("R7 aux after reset", {8'h00, d}, 16'h0000);
        check("R8 boot clear, no request", {15'd0, boot_en}, 16'd0);
        do_reset(8'h04, 1'b1, 1'b0, 1'b0);
        check("R8 boot set by status", {15'd0, boot_en}, 16'd1);
        do_reset(8'h00, 1'b0, 1'b1, 1'b1);
        check("R8 boot set by pins", {15'd0, boot_en}, 16'd1);
        do_reset(8'h00, 1'b0, 1'b1, 1'b0);
        check("R8 boot clear, ea low", {15'd0, boot_en}, 16'd0);
        do_reset(8'h00, 1'b1, 1'b1, 1'b1);
        check("R8 boot clear, psen high", {15'd0, boot_en}, 16'd0);
        sfr_write(A_AUX, 8'h20);
        check("R8 boot written by software", {15'd0, boot_en}, 16'd1);
        do_reset(8'h00, 1'b1, 1'b0, 1'b0);
    endtask

    // Byte access and selection (R1, R2).
    task automatic t_select_bytes();
        logic [7:0] d;
        sfr_write(A_LO, 8'h34);
        sfr_write(A_HI, 8'h12);
        check("R2 ptr0 via bytes", addr_out, 16'h1234);
        sfr_write(A_AUX, 8'h01);
        check("R1 ptr1 selected, still zero", addr_out, 16'h0000);
        sfr_write(A_HI, 8'hAB);
        sfr_write(A_LO, 8'hCD);
        sfr_read(A_LO, d);
        check("R2 read lo of ptr1", {8'h00, d}, 16'h00CD);
        sfr_read(A_HI, d);
        check("R2 read hi of ptr1", {8'h00, d}, 16'h00AB);
        sfr_write(A_AUX, 8'h00);
        check("R1 ptr0 kept value", addr_out, 16'h1234);
        sfr_read(A_HI, d);
        check("R2 read hi of ptr0", {8'h00, d}, 16'h0012);
        sfr_read(8'h81, d);
        check("R10 unmapped reads zero", {8'h00, d}, 16'h0000);
    endtask

    // Increment and load (R3, R4).
    task automatic t_inc_load();
        issue(2'd2, 16'hFFFF);
        check("R4 load ptr0", addr_out, 16'hFFFF);
        issue(2'd1, 16'h0000);
        check("R3 wrap to zero", addr_out, 16'h0000);
        issue(2'd2, 16'h00FF);
        issue(2'd1, 16'h0000);
        check("R3 carry into high byte", addr_out, 16'h0100);
        sfr_write(A_AUX, 8'h01);
        issue(2'd2, 16'h5A5A);
        check("R4 load ptr1", addr_out, 16'h5A5A);
        issue(2'd3, 16'h1111);
        check("R4 code 3 does nothing", addr_out, 16'h5A5A);
        issue(2'd1, 16'h0000);
        check("R3 inc ptr1", addr_out, 16'h5A5B);
        sfr_write(A_AUX, 8'h00);
        check("R3 ptr0 untouched by ptr1 ops", addr_out, 16'h0100);
    endtask

    // Aux format and increment toggle (R5, R6).
    task automatic t_aux();
        logic [7:0] d;
        sfr_write(A_AUX, 8'hFF);
        sfr_read(A_AUX, d);
        check("R5 aux read after FF write", {8'h00, d}, 16'h0029);
        check("R5 select follows bit 0", addr_out, 16'h5A5B);
        sfr_write(A_AUX, d + 8'h01);
        sfr_read(A_AUX, d);
        check("R6 toggle to ptr0, flag kept", {8'h00, d}, 16'h0028);
        check("R6 ptr0 now selected", addr_out, 16'h0100);
        sfr_write(A_AUX, d + 8'h01);
        sfr_read(A_AUX, d);
        check("R6 toggle back to ptr1", {8'h00, d}, 16'h0029);
        sfr_write(A_AUX, 8'h00);
    endtask

    // Priority and read timing (R9, R10).
    task automatic t_conflict();
        logic [7:0] d;
        issue(2'd2, 16'h20FE);
        sfr_addr = A_LO; sfr_wdata = 8'h77; sfr_wr = 1'b1; ptr_cmd = 2'd1;
        #0.5;
        d = sfr_rdata;
        check("R10 read shows pre-update value", {8'h00, d}, 16'h00FE);
        tick();
        sfr_wr = 1'b0; ptr_cmd = 2'd0;
        check("R9 increment beats byte write", addr_out, 16'h20FF);
        sfr_addr = A_HI; sfr_wdata = 8'h99; sfr_wr = 1'b1;
        ptr_cmd = 2'd2; ptr_imm = 16'h0C0D;
        tick();
        sfr_wr = 1'b0; ptr_cmd = 2'd0;
        check("R9 load beats byte write", addr_out, 16'h0C0D);
    endtask

    initial begin
        tick();
        t_reset_boot();
        t_select_bytes();
        t_inc_load();
        t_aux();
        t_conflict();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule